// File: doc/BRIEF.md
# Random Disjunctive Constraint Generator

This block produces random instances of disjunctive timing constraints, used to drive and stress hardware or software checkers of such constraints. Software configures an instance size: a variable count N, a disjunct count K per constraint, a constraint count M and a bound L on the constant magnitude. A start pulse captures the configuration and a seed, and the block then streams M constraints. Each constraint is K disjuncts. Each disjunct is a triple (from, to, z) and reads as "X[to] minus X[from] is at most z".

Random values come from an internal 32-bit LFSR. Each draw is reduced to its range by rejection against the largest whole multiple of that range that fits in the random word, so small ranges carry no modulo bias. Index pairs with equal members are redrawn. A finished constraint is held in an internal buffer and checked for repeated disjuncts. If it has any, the whole constraint is dropped and drawn again, so rejected constraints never reach the output. Accepted constraints leave over a valid/ready stream, with flags that mark the end of each constraint and the final constraint of the instance.

The user must pick K small enough that K distinct disjuncts exist for the given N and L. Otherwise the block keeps regenerating.

Top module: `rand_disj_gen`

## Requirements
- R1: A `start_i` pulse in the idle or finished state captures `seed_i`, `num_vars_i`, `disj_cnt_i`, `num_cons_i` and `bound_i`. A `start_i` pulse while an instance is being produced is ignored, and the stream continues unchanged.
- R2: Each constraint is exactly K disjuncts, sent back to back: `valid_o` stays high from the first to the last disjunct of a constraint. `last_disj_o` is high only on the K-th disjunct. A K of 0 is treated as 1, and a K above the buffer depth `K_MAX` (8) is treated as `K_MAX`.
- R3: `idx_from_o` and `idx_to_o` are both below N and differ from each other. An N below 2 is treated as 2.
- R4: `const_o` is a two's complement value of `CONST_W+1` bits (8 by default) that lies in [-L, L]. L = 0 gives z = 0 on every disjunct.
- R5: No emitted constraint holds two identical (from, to, z) triples. For N = 2, L = 0 and K = 2, every constraint is therefore {(0,1,0), (1,0,0)} in some order.
- R6: Exactly M×K disjuncts are emitted per instance. `last_cons_o` is high on every disjunct of the M-th constraint and on no other.
- R7: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and all output data and flags hold their values in the next cycle.
- R8: `done_o` is low after reset. It goes high in the cycle after the handshake of the final disjunct, and stays high with `valid_o` low until the next accepted start. M = 0 raises `done_o` without emitting anything.
- R9: The emitted sequence depends only on the seed and the configuration, not on the `ready_i` pattern. A different seed gives a different sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Captures the configuration and seed and begins an instance |
| seed_i | input | SEED_W | LFSR seed (0 is replaced by 1) |
| num_vars_i | input | VAR_W | Variable count N |
| disj_cnt_i | input | KW | Disjuncts per constraint K |
| num_cons_i | input | CNT_W | Constraint count M |
| bound_i | input | CONST_W | Constant bound L |
| ready_i | input | 1 | Downstream accepts the current disjunct |
| valid_o | output | 1 | A disjunct is presented |
| idx_from_o | output | VAR_W | Index subtracted in the difference |
| idx_to_o | output | VAR_W | Index the difference is taken from |
| const_o | output | CONST_W+1 | Signed bound z |
| last_disj_o | output | 1 | Final disjunct of the current constraint |
| last_cons_o | output | 1 | Disjunct belongs to the final constraint |
| done_o | output | 1 | Instance complete |

## Verification
Rejection sampling makes the latency from start to the first disjunct, and between constraints, data dependent: at least 3K+2 cycles, and more for every redraw. For that reason no result is tied to a fixed cycle count after start. Instead, the bench queues the expected framing flags for every disjunct when it issues a start. A monitor samples at the falling edge, takes a disjunct on each cycle where valid and ready are both high, and checks it against the head of that queue. Two results do have fixed timing relative to a handshake, and the monitor samples them exactly one cycle later: `done_o` after the final disjunct, and the held output after a stalled cycle. A second run with the same seed but a different ready pattern and an ignored restart must reproduce the first stream item for item.

// File: rtl/rdg_pkg.sv
package rdg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DRAW_A,
    S_DRAW_B,
    S_DRAW_C,
    S_CHECK,
    S_EMIT,
    S_DONE
  } gen_state_e;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

endpackage

// File: rtl/rdg_lfsr.sv
module rdg_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = W'(32'h8020_0003)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= W'(1);
    end else if (load_i) begin
      q <= (seed_i == '0) ? W'(1) : seed_i;  // all-zero state locks up
    end else if (step_i) begin
      q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
    end
  end

  assign state_o = q;

endmodule

// File: rtl/rdg_range.sv
// Unbiased reduction of a random word to [0, span): accept only below the
// largest multiple of span that fits in the word.
module rdg_range #(
  parameter int RND_W  = 16,
  parameter int SPAN_W = 8
) (
  input  logic [RND_W-1:0]  rnd_i,
  input  logic [SPAN_W-1:0] span_i,
  output logic              ok_o,
  output logic [SPAN_W-1:0] val_o
);

  localparam int WW = RND_W + 1;

  logic [WW-1:0] span_w, full_w, lim_w, rnd_w, rem_w;

  always_comb begin
    span_w = WW'(span_i);
    full_w = WW'(1) << RND_W;
    rnd_w  = WW'(rnd_i);
    lim_w  = (full_w / span_w) * span_w;
    rem_w  = rnd_w % span_w;
    ok_o   = rnd_w < lim_w;
    val_o  = rem_w[SPAN_W-1:0];
  end

endmodule

// File: rtl/rdg_dup.sv
// Flags any identical pair among the first cnt_i buffered entries.
module rdg_dup #(
  parameter int K_MAX = 8,
  parameter int KW    = 4,
  parameter int ENT_W = 20
) (
  input  logic [K_MAX-1:0][ENT_W-1:0] ent_i,
  input  logic [KW-1:0]               cnt_i,
  output logic                        dup_o
);

  logic [K_MAX-1:0][K_MAX-1:0] hit;

  for (genvar gi = 0; gi < K_MAX; gi++) begin : g_row
    for (genvar gj = 0; gj < K_MAX; gj++) begin : g_col
      if (gj > gi) begin : g_pair
        assign hit[gi][gj] = (ent_i[gi] == ent_i[gj]) && (KW'(gj) < cnt_i);
      end else begin : g_none
        assign hit[gi][gj] = 1'b0;
      end
    end
  end

  assign dup_o = |hit;

endmodule

// File: rtl/rand_disj_gen.sv
module rand_disj_gen
  import rdg_pkg::*;
#(
  parameter int  VAR_W   = 6,
  parameter int  CONST_W = 7,
  parameter int  CNT_W   = 12,
  parameter int  K_MAX   = 8,
  parameter int  RND_W   = 16,
  parameter int  SEED_W  = 32,
  localparam int KW      = $clog2(K_MAX + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [SEED_W-1:0]         seed_i,
  input  logic [VAR_W-1:0]          num_vars_i,
  input  logic [KW-1:0]             disj_cnt_i,
  input  logic [CNT_W-1:0]          num_cons_i,
  input  logic [CONST_W-1:0]        bound_i,
  input  logic                      ready_i,
  output logic                      valid_o,
  output logic [VAR_W-1:0]          idx_from_o,
  output logic [VAR_W-1:0]          idx_to_o,
  output logic signed [CONST_W:0]   const_o,
  output logic                      last_disj_o,
  output logic                      last_cons_o,
  output logic                      done_o
);

  localparam int ENT_W  = 2 * VAR_W + CONST_W + 1;
  localparam int SPAN_W = CONST_W + 1;
  localparam int IW     = (K_MAX > 1) ? $clog2(K_MAX) : 1;

  gen_state_e st_q;

  logic [VAR_W-1:0]   n_q, from_q, to_q;
  logic [KW-1:0]      k_q, slot_q, rd_q;
  logic [CNT_W-1:0]   m_q, cons_q;
  logic [CONST_W-1:0] l_q;
  logic [K_MAX-1:0][ENT_W-1:0] ent_q;

  logic [VAR_W-1:0]  n_eff;
  logic [KW-1:0]     k_eff;
  logic              start_ok, step;
  logic [SEED_W-1:0] lfsr;
  logic              idx_ok, c_ok, dup;
  logic [VAR_W-1:0]  idx_val;
  logic [SPAN_W-1:0] c_val, c_span, z_w;
  logic [ENT_W-1:0]  sel;

  // configuration clamps
  always_comb begin
    n_eff = (num_vars_i < VAR_W'(2)) ? VAR_W'(2) : num_vars_i;
    if (disj_cnt_i == '0)              k_eff = KW'(1);
    else if (disj_cnt_i > KW'(K_MAX))  k_eff = KW'(K_MAX);
    else                               k_eff = disj_cnt_i;
  end

  assign start_ok = start_i && (st_q == S_IDLE || st_q == S_DONE);
  assign step     = (st_q == S_DRAW_A) || (st_q == S_DRAW_B) || (st_q == S_DRAW_C);

  rdg_lfsr #(
    .W    (SEED_W),
    .TAPS (SEED_W'(LFSR_TAPS))
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .seed_i  (seed_i),
    .step_i  (step),
    .state_o (lfsr)
  );

  rdg_range #(
    .RND_W  (RND_W),
    .SPAN_W (VAR_W)
  ) u_idx_range (
    .rnd_i  (lfsr[RND_W-1:0]),
    .span_i (n_q),
    .ok_o   (idx_ok),
    .val_o  (idx_val)
  );

  assign c_span = {l_q, 1'b1};  // 2L+1 values

  rdg_range #(
    .RND_W  (RND_W),
    .SPAN_W (SPAN_W)
  ) u_const_range (
    .rnd_i  (lfsr[RND_W-1:0]),
    .span_i (c_span),
    .ok_o   (c_ok),
    .val_o  (c_val)
  );

  // shift [0,2L] to [-L,L]; result fits the signed field
  assign z_w = c_val - {1'b0, l_q};

  rdg_dup #(
    .K_MAX (K_MAX),
    .KW    (KW),
    .ENT_W (ENT_W)
  ) u_dup (
    .ent_i (ent_q),
    .cnt_i (k_q),
    .dup_o (dup)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      n_q    <= VAR_W'(2);
      k_q    <= KW'(1);
      m_q    <= '0;
      l_q    <= '0;
      slot_q <= '0;
      rd_q   <= '0;
      cons_q <= '0;
      from_q <= '0;
      to_q   <= '0;
      ent_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE, S_DONE: begin
          if (start_i) begin
            n_q    <= n_eff;
            k_q    <= k_eff;
            m_q    <= num_cons_i;
            l_q    <= bound_i;
            slot_q <= '0;
            rd_q   <= '0;
            cons_q <= '0;
            st_q   <= (num_cons_i == '0) ? S_DONE : S_DRAW_A;
          end
        end
        S_DRAW_A: begin
          if (idx_ok) begin
            from_q <= idx_val;
            st_q   <= S_DRAW_B;
          end
        end
        S_DRAW_B: begin
          if (idx_ok && idx_val != from_q) begin
            to_q <= idx_val;
            st_q <= S_DRAW_C;
          end
        end
        S_DRAW_C: begin
          if (c_ok) begin
            ent_q[slot_q[IW-1:0]] <= {from_q, to_q, z_w};
            if (slot_q == k_q - KW'(1)) begin
              st_q <= S_CHECK;
            end else begin
              slot_q <= slot_q + KW'(1);
              st_q   <= S_DRAW_A;
            end
          end
        end
        S_CHECK: begin
          if (dup) begin
            slot_q <= '0;  // drop whole constraint
            st_q   <= S_DRAW_A;
          end else begin
            rd_q <= '0;
            st_q <= S_EMIT;
          end
        end
        S_EMIT: begin
          if (ready_i) begin
            if (rd_q == k_q - KW'(1)) begin
              rd_q   <= '0;
              slot_q <= '0;
              if (cons_q == m_q - CNT_W'(1)) begin
                st_q <= S_DONE;
              end else begin
                cons_q <= cons_q + CNT_W'(1);
                st_q   <= S_DRAW_A;
              end
            end else begin
              rd_q <= rd_q + KW'(1);
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sel         = ent_q[rd_q[IW-1:0]];
  assign valid_o     = (st_q == S_EMIT);
  assign idx_from_o  = sel[ENT_W-1 -: VAR_W];
  assign idx_to_o    = sel[CONST_W+VAR_W -: VAR_W];
  assign const_o     = sel[CONST_W:0];
  assign last_disj_o = (rd_q == k_q - KW'(1));
  assign last_cons_o = (cons_q == m_q - CNT_W'(1));
  assign done_o      = (st_q == S_DONE);

endmodule

// File: rtl/rdg_chk.sv
module rdg_chk #(
  parameter int VAR_W   = 6,
  parameter int CONST_W = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ready_i,
  input logic                    valid_o,
  input logic [VAR_W-1:0]        idx_from_o,
  input logic [VAR_W-1:0]        idx_to_o,
  input logic signed [CONST_W:0] const_o,
  input logic                    last_disj_o,
  input logic                    last_cons_o,
  input logic                    done_o,
  input logic [VAR_W-1:0]        n_q,
  input logic [CONST_W-1:0]      l_q
);

  assert_burst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_disj_o |=> valid_o);

  assert_index_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (idx_from_o != idx_to_o) && (idx_from_o < n_q) && (idx_to_o < n_q));

  assert_const_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (const_o <= $signed({1'b0, l_q})) && (const_o >= -$signed({1'b0, l_q})));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(idx_from_o) && $stable(idx_to_o)
                            && $stable(const_o) && $stable(last_disj_o) && $stable(last_cons_o));

  assert_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_disj_o && last_cons_o |=> done_o);

  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

endmodule

bind rand_disj_gen rdg_chk #(
  .VAR_W   (VAR_W),
  .CONST_W (CONST_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_i     (ready_i),
  .valid_o     (valid_o),
  .idx_from_o  (idx_from_o),
  .idx_to_o    (idx_to_o),
  .const_o     (const_o),
  .last_disj_o (last_disj_o),
  .last_cons_o (last_cons_o),
  .done_o      (done_o),
  .n_q         (n_q),
  .l_q         (l_q)
);

// File: tb/rand_disj_gen_tb.sv
module rand_disj_gen_tb;

  localparam int VAR_W   = 6;
  localparam int CONST_W = 7;
  localparam int CNT_W   = 12;
  localparam int K_MAX   = 8;
  localparam int SEED_W  = 32;
  localparam int KW      = 4;
  localparam int IT_W    = 2 * VAR_W + CONST_W + 1 + 2;
  localparam int REC_D   = 512;

  logic                   clk, rst_n, start, ready;
  logic [SEED_W-1:0]      seed;
  logic [VAR_W-1:0]       nv;
  logic [KW-1:0]          kd;
  logic [CNT_W-1:0]       mc;
  logic [CONST_W-1:0]     lb;
  logic                   valid_o, last_disj_o, last_cons_o, done_o;
  logic [VAR_W-1:0]       from_o, to_o;
  logic signed [CONST_W:0] const_o;

  rand_disj_gen u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .seed_i      (seed),
    .num_vars_i  (nv),
    .disj_cnt_i  (kd),
    .num_cons_i  (mc),
    .bound_i     (lb),
    .ready_i     (ready),
    .valid_o     (valid_o),
    .idx_from_o  (from_o),
    .idx_to_o    (to_o),
    .const_o     (const_o),
    .last_disj_o (last_disj_o),
    .last_cons_o (last_cons_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int ncheck = 0;
  int nfail  = 0;
  int n_cur, k_cur, l_cur, rmode, cyc;
  logic [1:0] exp_q[$];
  logic [IT_W-1:0] rec[REC_D];
  logic [IT_W-1:0] ref_a[REC_D];
  int rec_n, ref_n;
  bit want_done, stall_chk;
  logic [IT_W-1:0] saved;
  logic [IT_W-1:0] cons_buf[K_MAX];
  int cons_n;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [IT_W-1:0] cur_item();
    return {from_o, to_o, const_o, last_disj_o, last_cons_o};
  endfunction

  // ready driver
  initial begin
    ready = 1'b1;
    cyc   = 0;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      case (rmode)
        1:       ready = (cyc % 3) != 0;
        2:       ready = (cyc % 5) < 2;
        default: ready = 1'b1;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    want_done = 0;
    stall_chk = 0;
    cons_n    = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (want_done) begin
        check(done_o && !valid_o, "R8 done after final handshake", {done_o, valid_o}, 2);
        want_done = 0;
      end
      if (stall_chk) begin
        check(valid_o && cur_item() == saved, "R7 hold under stall", cur_item(), saved);
        stall_chk = 0;
      end
      if (valid_o && !ready) begin
        stall_chk = 1;
        saved     = cur_item();
      end
      if (valid_o && ready) begin
        logic [1:0] e;
        int z;
        z = int'(const_o);
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected extra disjunct", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(last_disj_o == e[1], "R2 last_disj flag", last_disj_o, e[1]);
          check(last_cons_o == e[0], "R6 last_cons flag", last_cons_o, e[0]);
        end
        check(from_o != to_o, "R3 distinct indices", from_o, to_o);
        check(int'(from_o) < n_cur && int'(to_o) < n_cur, "R3 index below N",
              (from_o > to_o) ? from_o : to_o, n_cur - 1);
        check(z >= -l_cur && z <= l_cur, "R4 constant in range", z, l_cur);
        if (rec_n < REC_D) rec[rec_n] = cur_item();
        rec_n++;
        if (cons_n < K_MAX) cons_buf[cons_n] = cur_item();
        cons_n++;
        if (last_disj_o) begin
          bit dup;
          dup = 0;
          for (int a = 0; a < cons_n && a < K_MAX; a++)
            for (int b = a + 1; b < cons_n && b < K_MAX; b++)
              if (cons_buf[a][IT_W-1:2] == cons_buf[b][IT_W-1:2]) dup = 1;
          check(!dup, "R5 no repeated disjunct", dup, 0);
          check(cons_n == k_cur, "R2 disjuncts per constraint", cons_n, k_cur);
          cons_n = 0;
          if (last_cons_o) want_done = 1;
        end
      end
    end
  end

  task automatic pulse_start(input logic [SEED_W-1:0] s, input int n, input int k,
                             input int m, input int l);
    @(posedge clk);
    #2;
    seed  = s;
    nv    = VAR_W'(n);
    kd    = KW'(k);
    mc    = CNT_W'(m);
    lb    = CONST_W'(l);
    start = 1'b1;
    @(posedge clk);
    #2;
    start = 1'b0;
  endtask

  task automatic run_case(input logic [SEED_W-1:0] s, input int n, input int k, input int m,
                          input int l, input int mode, input bit inject);
    n_cur  = (n < 2) ? 2 : n;
    k_cur  = (k == 0) ? 1 : ((k > K_MAX) ? K_MAX : k);
    l_cur  = l;
    rmode  = mode;
    rec_n  = 0;
    cons_n = 0;
    exp_q.delete();
    for (int c = 0; c < m; c++)
      for (int d = 0; d < k_cur; d++)
        exp_q.push_back({d == k_cur - 1, c == m - 1});
    pulse_start(s, n, k, m, l);
    if (inject) begin
      repeat (40) @(posedge clk);
      #2;
      seed  = s ^ 32'h5A5A_0F0F;
      kd    = KW'(5);
      mc    = CNT_W'(2);
      start = 1'b1;
      @(posedge clk);
      #2;
      start = 1'b0;
    end
    @(negedge clk);
    while (!done_o) @(negedge clk);
    check(exp_q.size() == 0, "R6 all expected disjuncts seen", exp_q.size(), 0);
    check(rec_n == m * k_cur, "R6 disjunct count", rec_n, m * k_cur);
    rmode = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    seed  = '0;
    nv    = '0;
    kd    = '0;
    mc    = '0;
    lb    = '0;
    rmode = 0;
    n_cur = 2;
    k_cur = 1;
    l_cur = 0;
    rec_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(!valid_o, "R8 reset valid low", valid_o, 0);
    check(!done_o, "R8 reset done low", done_o, 0);

    // reference stream, ready always high
    run_case(32'h1234_ABCD, 10, 3, 20, 5, 0, 0);
    ref_n = rec_n;
    for (int i = 0; i < REC_D; i++) ref_a[i] = rec[i];

    // same seed, backpressure and an ignored restart (R1, R9)
    run_case(32'h1234_ABCD, 10, 3, 20, 5, 1, 1);
    check(rec_n == ref_n, "R1 restart ignored, count", rec_n, ref_n);
    begin
      int diff;
      diff = 0;
      for (int i = 0; i < ref_n && i < REC_D; i++) if (rec[i] != ref_a[i]) diff++;
      check(diff == 0, "R9 same seed same stream", diff, 0);
    end

    // different seed must differ (R9)
    run_case(32'h0BAD_F00D, 10, 3, 20, 5, 2, 0);
    begin
      int diff;
      diff = 0;
      for (int i = 0; i < ref_n && i < REC_D; i++) if (rec[i] != ref_a[i]) diff++;
      check(diff > 0, "R9 other seed other stream", diff, 1);
    end

    // smallest space: N=2, L=0, K=2 (R5)
    run_case(32'h0000_0007, 2, 2, 6, 0, 2, 0);
    for (int i = 0; i < rec_n && i < REC_D; i++) begin
      logic [VAR_W-1:0] f, t;
      logic signed [CONST_W:0] zz;
      {f, t, zz} = rec[i][IT_W-1:2];
      check(int'(f) + int'(t) == 1 && zz == 0, "R5 only two legal triples", {f, t, zz}, 0);
    end

    // clamps: N=0 -> 2, K=0 -> 1 (R2, R3)
    run_case(32'h0000_0000, 0, 0, 5, 3, 1, 0);

    // K above K_MAX -> K_MAX, wide constant range (R2, R4)
    run_case(32'hCAFE_1234, 60, 12, 4, 100, 0, 0);

    // M = 0: done without output (R8)
    run_case(32'h0000_0011, 5, 2, 0, 1, 0, 0);
    check(done_o && rec_n == 0, "R8 empty instance done", rec_n, 0);

    $display("  [TB] %0d tests run, %0d failed", ncheck, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ncheck++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ncheck, nfail);
    $finish;
  end

endmodule